// File: doc/BRIEF.md
# Hotspot Detecting Drowsy Line Controller

This block decides, line by line, which lines of an instruction cache sit in a low-leakage drowsy state and which stay active. It watches the branch target buffer lookups. Each buffer entry carries two saturating execution counters: one for the block reached when the branch is taken, and one for the block reached when it falls through. When a lookup selects a counter whose top bit is set, the code is running in a hot region, and the block raises a global hot flag. While that flag is up, every cache line that is fetched gets a keep mask bit.

When a programmable window elapses, the block does several things at once. Every line without a keep bit goes drowsy. All keep bits are cleared. The hot flag drops, and every counter is halved. A predicted-taken backward branch with a saturated counter signals a loop, and it issues the same line turn-off at once, without waiting for the window to end. A fetch from a drowsy line wakes that line. For that cycle the block raises a stall flag to account for the wake-up penalty.

Top module: `hot_line_ctrl`

## Requirements
- R1: After reset all lines are active (`drowsy_o` all zero), `turn_off_o`, `hot_o` and `stall_o` are 0, and all counters and keep bits are zero.
- R2: On a valid lookup that hits, the taken counter of entry `btb_idx_i` increments when `btb_taken_i` is 1, and the fall-through counter increments when it is 0. A lookup that misses changes no counter and leaves `hot_o` unchanged.
- R3: Counters are clog2(TACC)+1 bits wide and hold their value once their top bit is 1. With TACC=4, the top bit is bit 2, and the fifth hit on the same counter is the first that sees it set.
- R4: A replacement strobe clears both counters of entry `btb_repl_idx_i`.
- R5: A hitting lookup whose selected counter has its top bit set makes `hot_o` 1 on the next cycle. One whose selected counter has its top bit clear makes `hot_o` 0.
- R6: A line fetched while `hot_o` is 1 gets its keep bit set.
- R7: At window expiry, every line without a keep bit goes drowsy and all keep bits clear. `hot_o` goes to 0 and every counter shifts right by one. All of these are visible on the next cycle, together with a one-cycle `turn_off_o` pulse.
- R8: A hitting, predicted-taken, backward lookup whose taken counter has its top bit set puts every line without a keep bit into drowsy mode. It also pulses `turn_off_o` on the next cycle. Keep bits are preserved.
- R9: A fetch of a drowsy line raises `stall_o` combinationally in that cycle, and the line reads active from the next cycle on.
- R10: The window expires after `win_len_i` cycles with a non-zero length. A length of 0 stops the window.
- R11: A line fetched in the same cycle as a turn-off stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_len_i | input | WIN_W | Window length in cycles, 0 stops the window |
| btb_vld_i | input | 1 | Lookup valid |
| btb_hit_i | input | 1 | Lookup hit |
| btb_taken_i | input | 1 | Predicted taken |
| btb_back_i | input | 1 | Branch target lies backward |
| btb_idx_i | input | clog2(ENTRIES) | Entry index of the lookup |
| btb_repl_i | input | 1 | Entry replacement strobe |
| btb_repl_idx_i | input | clog2(ENTRIES) | Entry being replaced |
| acc_vld_i | input | 1 | Cache line fetch strobe |
| acc_line_i | input | clog2(LINES) | Fetched line index |
| drowsy_o | output | LINES | Per-line drowsy enable |
| turn_off_o | output | 1 | One-cycle global turn-off pulse |
| hot_o | output | 1 | Global hot flag |
| stall_o | output | 1 | Wake-up stall for the current fetch |

## Verification
Two pairs of events can fall in the same cycle. The first is a line fetch together with a turn-off: the bench fetches a drowsy line in the very cycle the window is set to expire. It then expects the stall, the turn-off pulse, and that line alone to stay active, with every other line drowsy. The second is the keep mask together with an expiry. The bench marks lines while the hot flag is up and lets the window expire, and those lines survive. A second turn-off then drowses them, which shows that the keep bits were cleared. The bench also checks counter halving, by counting the hits needed to reach the top bit again after the window.

// File: rtl/hld_pkg.sv
package hld_pkg;
  typedef struct packed {
    logic vld;
    logic hit;
    logic taken;
    logic back;
  } lookup_t;

  function automatic int cnt_width(input int tacc);
    return $clog2(tacc) + 1;
  endfunction
endpackage

// File: rtl/hld_window_timer.sv
module hld_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             expire_o
);
  logic [WIN_W-1:0] cnt_q;
  logic             en;

  assign en       = (win_len_i != '0);
  assign expire_o = en && (cnt_q >= win_len_i - WIN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + WIN_W'(1);
  end

  AST_EXPIRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && win_len_i > WIN_W'(1) && $stable(win_len_i)) |=> (win_len_i <= WIN_W'(1) || !expire_o)); // R10
endmodule

// File: rtl/hld_btb_counters.sv
module hld_btb_counters
  import hld_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TACC    = 4,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CW     = cnt_width(TACC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lookup_t       lk_i,
  input  logic [IW-1:0] lk_idx_i,
  input  logic          repl_i,
  input  logic [IW-1:0] repl_idx_i,
  input  logic          halve_i,
  output logic          hot_hit_o,
  output logic          cold_hit_o,
  output logic          early_o
);
  logic [CW-1:0] tgt_q [ENTRIES];
  logic [CW-1:0] fth_q [ENTRIES];
  logic          sel_msb;
  logic          lk_on;

  assign lk_on      = lk_i.vld && lk_i.hit;
  assign sel_msb    = lk_i.taken ? tgt_q[lk_idx_i][CW-1] : fth_q[lk_idx_i][CW-1];
  assign hot_hit_o  = lk_on && sel_msb;
  assign cold_hit_o = lk_on && !sel_msb;
  assign early_o    = hot_hit_o && lk_i.taken && lk_i.back;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel_e, repl_e;
    assign sel_e  = lk_on && (lk_idx_i == IW'(e));
    assign repl_e = repl_i && (repl_idx_i == IW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_q[e] <= '0;
        fth_q[e] <= '0;
      end else if (repl_e) begin
        tgt_q[e] <= '0;
        fth_q[e] <= '0;
      end else if (halve_i) begin
        tgt_q[e] <= tgt_q[e] >> 1;
        fth_q[e] <= fth_q[e] >> 1;
      end else if (sel_e) begin
        if (lk_i.taken && !tgt_q[e][CW-1])  tgt_q[e] <= tgt_q[e] + CW'(1);
        if (!lk_i.taken && !fth_q[e][CW-1]) fth_q[e] <= fth_q[e] + CW'(1);
      end
    end

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_e && lk_i.taken && tgt_q[e][CW-1] && !repl_e && !halve_i) |=> $stable(tgt_q[e])); // R3
    AST_REPL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      repl_e |=> (tgt_q[e] == '0 && fth_q[e] == '0)); // R4
    AST_HALVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halve_i && !repl_e) |=> (tgt_q[e] == ($past(tgt_q[e]) >> 1))); // R7
  end
endmodule

// File: rtl/hld_line_ctrl.sv
module hld_line_ctrl #(
  parameter int LINES = 16,
  localparam int LW   = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hot_i,
  input  logic             acc_vld_i,
  input  logic [LW-1:0]    acc_line_i,
  input  logic             expire_i,
  input  logic             off_i,
  output logic [LINES-1:0] drowsy_o,
  output logic             stall_o
);
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] drowsy_q;

  assign drowsy_o = drowsy_q;
  assign stall_o  = acc_vld_i && drowsy_q[acc_line_i];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic acc_l;
    assign acc_l = acc_vld_i && (acc_line_i == LW'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     drowsy_q[l] <= 1'b0;
      else if (acc_l)  drowsy_q[l] <= 1'b0;
      else if (off_i)  drowsy_q[l] <= !mask_q[l];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             mask_q[l] <= 1'b0;
      else if (expire_i)       mask_q[l] <= 1'b0;
      else if (acc_l && hot_i) mask_q[l] <= 1'b1;
    end
  end

  AST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i |=> !drowsy_q[$past(acc_line_i)]); // R9
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (mask_q == '0)); // R7
endmodule

// File: rtl/hot_line_ctrl.sv
module hot_line_ctrl
  import hld_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int LINES   = 16,
  parameter int TACC    = 4,
  parameter int WIN_W   = 16,
  localparam int IW     = $clog2(ENTRIES),
  localparam int LW     = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             btb_vld_i,
  input  logic             btb_hit_i,
  input  logic             btb_taken_i,
  input  logic             btb_back_i,
  input  logic [IW-1:0]    btb_idx_i,
  input  logic             btb_repl_i,
  input  logic [IW-1:0]    btb_repl_idx_i,
  input  logic             acc_vld_i,
  input  logic [LW-1:0]    acc_line_i,
  output logic [LINES-1:0] drowsy_o,
  output logic             turn_off_o,
  output logic             hot_o,
  output logic             stall_o
);
  lookup_t lk;
  logic    expire, hot_hit, cold_hit, early, off;
  logic    hot_q, off_q;

  assign lk  = '{vld: btb_vld_i, hit: btb_hit_i, taken: btb_taken_i, back: btb_back_i};
  assign off = expire || early;

  hld_window_timer #(.WIN_W(WIN_W)) u_win (
    .clk_i, .rst_ni, .win_len_i, .expire_o(expire)
  );

  hld_btb_counters #(.ENTRIES(ENTRIES), .TACC(TACC)) u_cnt (
    .clk_i, .rst_ni, .lk_i(lk), .lk_idx_i(btb_idx_i),
    .repl_i(btb_repl_i), .repl_idx_i(btb_repl_idx_i), .halve_i(expire),
    .hot_hit_o(hot_hit), .cold_hit_o(cold_hit), .early_o(early)
  );

  hld_line_ctrl #(.LINES(LINES)) u_line (
    .clk_i, .rst_ni, .hot_i(hot_q), .acc_vld_i, .acc_line_i,
    .expire_i(expire), .off_i(off), .drowsy_o, .stall_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hot_q <= 1'b0;
    else if (expire)   hot_q <= 1'b0;
    else if (hot_hit)  hot_q <= 1'b1;
    else if (cold_hit) hot_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= 1'b0;
    else         off_q <= off;
  end

  assign hot_o      = hot_q;
  assign turn_off_o = off_q;

  AST_HOT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_hit && !expire) |=> hot_o); // R5
  AST_HOT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !hot_o); // R7
  AST_EARLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early |=> turn_off_o); // R8
  AST_OFF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (turn_off_o && !$past(expire) && !$past(early)) |-> 1'b0); // R7
endmodule

// File: tb/hot_line_ctrl_test.sv
`timescale 1ns/1ps
module hot_line_ctrl_test;
  localparam int ENTRIES = 8, LINES = 16, TACC = 4, WIN_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [WIN_W-1:0] win_len = '0;
  logic vld = 0, hit = 0, taken = 0, back = 0, repl = 0, acc = 0;
  logic [2:0] idx = '0, ridx = '0;
  logic [3:0] line = '0;
  logic [LINES-1:0] drowsy;
  logic off, hot, stall;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hot_line_ctrl #(.ENTRIES(ENTRIES), .LINES(LINES), .TACC(TACC), .WIN_W(WIN_W)) uut (
    .clk_i(clk), .rst_ni, .win_len_i(win_len),
    .btb_vld_i(vld), .btb_hit_i(hit), .btb_taken_i(taken), .btb_back_i(back),
    .btb_idx_i(idx), .btb_repl_i(repl), .btb_repl_idx_i(ridx),
    .acc_vld_i(acc), .acc_line_i(line),
    .drowsy_o(drowsy), .turn_off_o(off), .hot_o(hot), .stall_o(stall)
  );

  // [8]vld [7]hit [6]taken [5]back [4:2]idx [1]exp_hot [0]exp_off
  localparam logic [8:0] VEC [11] = '{
    9'b1110_001_00, 9'b1110_001_00, 9'b1110_001_00, 9'b1110_001_00,
    9'b1110_001_10, 9'b1100_001_00, 9'b1110_001_10, 9'b1010_001_10,
    9'b1111_001_11, 9'b0000_000_10, 9'b1111_010_00
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    vld = 0; hit = 0; taken = 0; back = 0; repl = 0; acc = 0;
  endtask

  task automatic look(input bit t, input bit b, input logic [2:0] i);
    vld = 1; hit = 1; taken = t; back = b; idx = i;
    @(negedge clk);
    idle();
  endtask

  task automatic fetch(input logic [3:0] l, input bit exp_stall, input string req);
    acc = 1; line = l;
    #1 chk(stall == exp_stall, req, 32'(stall), 32'(exp_stall));
    @(negedge clk);
    idle();
    chk(drowsy[l] == 1'b0, "R9 woken", 32'(drowsy[l]), 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(drowsy == '0, "R1 drowsy", 32'(drowsy), 0);
    chk(!off && !hot && !stall, "R1 flags", {off, hot, stall}, 0);

    // R2 R3 R5 R8 table walk
    foreach (VEC[k]) begin
      {vld, hit, taken, back, idx} = VEC[k][8:2];
      @(negedge clk);
      idle();
      chk(hot == VEC[k][1], $sformatf("R5 hot vec%0d", k), 32'(hot), 32'(VEC[k][1]));
      chk(off == VEC[k][0], $sformatf("R8 off vec%0d", k), 32'(off), 32'(VEC[k][0]));
    end
    chk(drowsy == '1, "R8 all drowsy", 32'(drowsy), 32'hffff);

    // R10 window stopped
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(!off, "R10 no expiry at len 0", 32'(off), 0);
    end

    // R9 wake
    fetch(4'd5, 1'b1, "R9 stall on drowsy");
    fetch(4'd5, 1'b0, "R9 no stall when active");

    // R6 keep mask and early turn-off
    look(1, 0, 3'd1);
    chk(hot, "R5 hot set", 32'(hot), 1);
    fetch(4'd3, 1'b1, "R6 fetch hot");
    fetch(4'd5, 1'b0, "R6 fetch hot");
    look(0, 0, 3'd1);
    chk(!hot, "R5 hot clear", 32'(hot), 0);
    fetch(4'd7, 1'b1, "R6 fetch cold");
    look(1, 1, 3'd1);
    chk(off, "R8 early", 32'(off), 1);
    chk(drowsy == 16'hffd7, "R6 kept lines", 32'(drowsy), 32'hffd7);

    // R7 R10 window expiry
    win_len = 16'd3;
    repeat (2) @(negedge clk);
    chk(!off, "R10 before expiry", 32'(off), 0);
    @(negedge clk);
    win_len = '0;
    chk(off, "R10 expiry", 32'(off), 1);
    chk(!hot, "R7 hot cleared", 32'(hot), 0);
    chk(drowsy == 16'hffd7, "R7 masked lines active", 32'(drowsy), 32'hffd7);
    look(1, 0, 3'd1);
    chk(!hot, "R7 halved 1", 32'(hot), 0);
    look(1, 0, 3'd1);
    chk(!hot, "R7 halved 2", 32'(hot), 0);
    look(1, 0, 3'd1);
    chk(hot, "R7 halved 3", 32'(hot), 1);
    look(1, 1, 3'd1);
    chk(drowsy == '1, "R7 masks cleared", 32'(drowsy), 32'hffff);

    // R4 replacement
    repl = 1; ridx = 3'd1;
    @(negedge clk);
    idle();
    look(1, 0, 3'd1);
    chk(!hot, "R4 cleared counters", 32'(hot), 0);

    // R11 fetch with turn-off in same cycle
    win_len = 16'd1; acc = 1; line = 4'd9;
    #1 chk(stall, "R11 stall", 32'(stall), 1);
    @(negedge clk);
    win_len = '0; idle();
    chk(off, "R11 off", 32'(off), 1);
    chk(drowsy == 16'hfdff, "R11 fetched line active", 32'(drowsy), 32'hfdff);

    done = 1;
    summary();
  end
endmodule